// File: doc/BRIEF.md
# Multi-Thread Store Buffer with Read-After-Write Forwarding

This block holds the committed stores of several hardware threads until the second-level cache has taken and acknowledged them. The threads share one physical array, and each thread owns a fixed partition of that array. A store enters with its thread number, its ordering mode, a doubleword address, a byte mask and the data. It is not checked against the L1 tag and never allocates in the L1. Each partition is a circular queue. Stores leave a partition in program order through a single drain port. A round-robin arbiter picks which thread uses that port in a given cycle.

A store sent under total-store-order rules blocks the next such store of its own thread until the cache acknowledges it. Relaxed-order stores go out without that limit. Each acknowledgement names the thread and the slot of the store, and it frees that slot. When the acknowledgement reports that the line is present in the L1, the block issues a data-cache write with the stored bytes in the same cycle.

A load lookup compares one doubleword address and byte mask against the live stores of the same thread. The youngest overlapping store forwards its data when it covers every requested byte. If it covers only some of the requested bytes, the block reports a conflict.

Top module: `thrd_store_buffer`

## Requirements
- R1: After reset every partition is empty: `drn_valid`, `ins_full`, `ld_hit`, `ld_conflict` and `dc_wr_valid` are 0.
- R2: `ins_full` is 1 exactly when the partition of `ins_tid` holds DEPTH (8) entries between its oldest unreleased slot and its tail. A store offered while full is dropped. An acknowledged slot is released from the oldest end, at most one per cycle, on the clock edge after the edge that acknowledged it.
- R3: The stores of one thread appear on the drain port in the order they were inserted, with the address, mask and data given at insert.
- R4: A thread's next unsent store in total-store order (`ins_rmo`=0) is not offered while an earlier store of that thread in total-store order is still unacknowledged. This holds the thread's later stores behind it too.
- R5: A relaxed-order store (`ins_rmo`=1) is offered regardless of how many stores of its thread are outstanding.
- R6: When `ld_valid` is 1, the youngest live store of thread `ld_tid` whose address equals `ld_addr` and whose mask shares a byte with `ld_mask` is selected. If its mask contains every bit of `ld_mask`, then `ld_hit`=1 and `ld_data` equals its data. A store becomes visible to lookups in the cycle after its insert.
- R7: Stores of other threads, and stores already acknowledged, never cause `ld_hit` or `ld_conflict`.
- R8: If the selected store lacks a byte of `ld_mask`, then `ld_conflict`=1 and `ld_hit`=0.
- R9: `ack_valid` with `ack_tid`/`ack_idx` frees that slot. In the same cycle, `dc_wr_valid` equals `ack_l1hit`, and `dc_wr_addr`/`dc_wr_mask`/`dc_wr_data` carry the acknowledged store.
- R10: Among threads with an offerable store, the drain port grants the first one found at or after a rotating pointer. The pointer starts at thread 0 and moves to the thread after the granted one on each accepted drain (`drn_valid` and `drn_ready`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ins_valid | input | 1 | Store insert request |
| ins_tid | input | TW | Thread of the store |
| ins_rmo | input | 1 | 1 = relaxed order, 0 = total store order |
| ins_addr | input | AW | Doubleword address |
| ins_mask | input | DW/8 | Byte mask |
| ins_data | input | DW | Store data |
| ins_full | output | 1 | Partition of `ins_tid` is full |
| ld_valid | input | 1 | Load lookup request |
| ld_tid | input | TW | Thread of the load |
| ld_addr | input | AW | Load doubleword address |
| ld_mask | input | DW/8 | Bytes the load needs |
| ld_hit | output | 1 | Full forward available |
| ld_conflict | output | 1 | Partial overlap with youngest match |
| ld_data | output | DW | Forwarded data |
| drn_valid | output | 1 | A store is offered to L2 |
| drn_ready | input | 1 | L2 request side takes it |
| drn_tid | output | TW | Thread of offered store |
| drn_idx | output | PW | Slot of offered store, returned with its ack |
| drn_rmo | output | 1 | Ordering mode of offered store |
| drn_addr | output | AW | Address of offered store |
| drn_mask | output | DW/8 | Mask of offered store |
| drn_data | output | DW | Data of offered store |
| ack_valid | input | 1 | Store acknowledge from L2 |
| ack_tid | input | TW | Thread of acknowledged store |
| ack_idx | input | PW | Slot of acknowledged store |
| ack_l1hit | input | 1 | Line is present in the L1 data cache |
| dc_wr_valid | output | 1 | Write the store into the L1 data cache |
| dc_wr_addr | output | AW | Data-cache write address |
| dc_wr_mask | output | DW/8 | Data-cache write byte mask |
| dc_wr_data | output | DW | Data-cache write data |

## Verification
The hardest state to reach from the ports combines two conditions. One thread holds a total-store-order store in flight, with later stores stuck behind it. Meanwhile other threads keep draining relaxed stores, and their acknowledgements come back out of order, so slots free in the middle of a partition while the oldest end lags. The stimulus holds acknowledgements back for some cycles and then returns them in random order, with random L1-hit flags. Random inserts of both modes go to a small address pool, and lookups with mixed masks run every cycle. Together these keep several overlapping stores per thread alive during drains and frees. Directed phases first fill a partition to overflow, force a partial-overlap lookup, and show the rotation of grants.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;
   // Ordering mode carried by each buffered store.
   typedef enum logic {
      ORD_TSO = 1'b0,
      ORD_RMO = 1'b1
   } ord_e;
endpackage

// File: rtl/sbuf_rr_arb.sv
module sbuf_rr_arb #(
   parameter int N = 4,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  req,
   input  logic          adv,
   output logic [N-1:0]  gnt,
   output logic [IW-1:0] gnt_id,
   output logic          any
);
   logic [IW-1:0] rr_q;

   // Scan downward so the nearest requester at or after rr_q wins last.
   always_comb begin
      gnt_id = '0;
      any    = 1'b0;
      for (int k = N - 1; k >= 0; k--) begin
         if (req[(int'(rr_q) + k) % N]) begin
            gnt_id = IW'((int'(rr_q) + k) % N);
            any    = 1'b1;
         end
      end
      gnt = any ? (N'(1) << gnt_id) : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             rr_q <= '0;
      else if (adv && any)    rr_q <= IW'((int'(gnt_id) + 1) % N);
   end

   a_r10_onehot_grant: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt));
   a_r10_grant_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt & ~req) == '0);
endmodule

// File: rtl/sbuf_part.sv
module sbuf_part
   import sbuf_pkg::*;
#(
   parameter int DEPTH = 8,
   parameter int AW    = 40,
   parameter int DW    = 64,
   localparam int MW   = DW / 8,
   localparam int PW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ins_en,
   input  logic          ins_rmo,
   input  logic [AW-1:0] ins_addr,
   input  logic [MW-1:0] ins_mask,
   input  logic [DW-1:0] ins_data,
   output logic          full,
   input  logic [AW-1:0] ld_addr,
   input  logic [MW-1:0] ld_mask,
   output logic          ld_hit,
   output logic          ld_conf,
   output logic [DW-1:0] ld_data,
   output logic          snd_req,
   output logic [PW-1:0] snd_idx,
   output logic          snd_rmo,
   output logic [AW-1:0] snd_addr,
   output logic [MW-1:0] snd_mask,
   output logic [DW-1:0] snd_data,
   input  logic          snd_take,
   input  logic          ack_en,
   input  logic [PW-1:0] ack_idx,
   output logic [AW-1:0] ack_addr,
   output logic [MW-1:0] ack_mask,
   output logic [DW-1:0] ack_data
);
   logic [AW-1:0]    addr_q [DEPTH];
   logic [MW-1:0]    mask_q [DEPTH];
   logic [DW-1:0]    data_q [DEPTH];
   ord_e             ord_q  [DEPTH];
   logic [DEPTH-1:0] vld_q;
   logic [PW:0]      head_q, snd_q, tail_q;
   logic             tso_busy_q;

   logic [PW-1:0] head_s, snd_s, tail_s;
   assign head_s = head_q[PW-1:0];
   assign snd_s  = snd_q[PW-1:0];
   assign tail_s = tail_q[PW-1:0];

   assign full    = (tail_q - head_q) == (PW+1)'(DEPTH);
   assign snd_idx = snd_s;
   assign snd_rmo = (ord_q[snd_s] == ORD_RMO);
   assign snd_req = (snd_q != tail_q) && (snd_rmo || !tso_busy_q);
   assign snd_addr = addr_q[snd_s];
   assign snd_mask = mask_q[snd_s];
   assign snd_data = data_q[snd_s];
   assign ack_addr = addr_q[ack_idx];
   assign ack_mask = mask_q[ack_idx];
   assign ack_data = data_q[ack_idx];

   // Youngest overlapping live store, ranked by distance from the head.
   logic          fnd;
   logic [PW-1:0] best, best_age, age;
   always_comb begin
      fnd      = 1'b0;
      best     = '0;
      best_age = '0;
      for (int i = 0; i < DEPTH; i++) begin
         age = PW'(i) - head_s;
         if (vld_q[i] && addr_q[i] == ld_addr && |(mask_q[i] & ld_mask)
             && (!fnd || age > best_age)) begin
            fnd      = 1'b1;
            best     = PW'(i);
            best_age = age;
         end
      end
      ld_hit  = fnd && ((ld_mask & ~mask_q[best]) == '0);
      ld_conf = fnd && !ld_hit;
      ld_data = data_q[best];
   end

   always_ff @(posedge clk) begin
      if (ins_en) begin
         addr_q[tail_s] <= ins_addr;
         mask_q[tail_s] <= ins_mask;
         data_q[tail_s] <= ins_data;
         ord_q[tail_s]  <= ins_rmo ? ORD_RMO : ORD_TSO;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q      <= '0;
         head_q     <= '0;
         snd_q      <= '0;
         tail_q     <= '0;
         tso_busy_q <= 1'b0;
      end else begin
         if (head_q != tail_q && !vld_q[head_s]) head_q <= head_q + 1'b1;
         if (ins_en) begin
            vld_q[tail_s] <= 1'b1;
            tail_q        <= tail_q + 1'b1;
         end
         if (ack_en) begin
            vld_q[ack_idx] <= 1'b0;
            if (ord_q[ack_idx] == ORD_TSO) tso_busy_q <= 1'b0;
         end
         if (snd_take) begin
            snd_q <= snd_q + 1'b1;
            if (!snd_rmo) tso_busy_q <= 1'b1;
         end
      end
   end

   a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      (tail_q - head_q) <= (PW+1)'(DEPTH));
   a_r4_single_tso: assert property (@(posedge clk) disable iff (!rst_n)
      snd_take && !snd_rmo |-> !tso_busy_q);

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot_chk
      a_r9_ack_frees: assert property (@(posedge clk) disable iff (!rst_n)
         ack_en && ack_idx == PW'(g) |=> !vld_q[g]);
      a_r9_free_needs_ack: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(vld_q[g]) |-> $past(ack_en && ack_idx == PW'(g)));
   end
endmodule

// File: rtl/thrd_store_buffer.sv
module thrd_store_buffer #(
   parameter int NTHR  = 4,
   parameter int DEPTH = 8,
   parameter int AW    = 40,
   parameter int DW    = 64,
   localparam int MW   = DW / 8,
   localparam int TW   = $clog2(NTHR),
   localparam int PW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ins_valid,
   input  logic [TW-1:0] ins_tid,
   input  logic          ins_rmo,
   input  logic [AW-1:0] ins_addr,
   input  logic [MW-1:0] ins_mask,
   input  logic [DW-1:0] ins_data,
   output logic          ins_full,
   input  logic          ld_valid,
   input  logic [TW-1:0] ld_tid,
   input  logic [AW-1:0] ld_addr,
   input  logic [MW-1:0] ld_mask,
   output logic          ld_hit,
   output logic          ld_conflict,
   output logic [DW-1:0] ld_data,
   output logic          drn_valid,
   input  logic          drn_ready,
   output logic [TW-1:0] drn_tid,
   output logic [PW-1:0] drn_idx,
   output logic          drn_rmo,
   output logic [AW-1:0] drn_addr,
   output logic [MW-1:0] drn_mask,
   output logic [DW-1:0] drn_data,
   input  logic          ack_valid,
   input  logic [TW-1:0] ack_tid,
   input  logic [PW-1:0] ack_idx,
   input  logic          ack_l1hit,
   output logic          dc_wr_valid,
   output logic [AW-1:0] dc_wr_addr,
   output logic [MW-1:0] dc_wr_mask,
   output logic [DW-1:0] dc_wr_data
);
   if (NTHR < 2 || (NTHR & (NTHR - 1)) != 0)
      $error("NTHR must be a power of two, at least 2");
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0)
      $error("DEPTH must be a power of two, at least 2");
   if (DW % 8 != 0 || AW < 1)
      $error("DW must be a byte multiple and AW positive");

   logic [NTHR-1:0] p_full, p_hit, p_conf, p_req, p_gnt, p_rmo;
   logic [DW-1:0]   p_ldd  [NTHR];
   logic [PW-1:0]   p_idx  [NTHR];
   logic [AW-1:0]   p_sa   [NTHR];
   logic [MW-1:0]   p_sm   [NTHR];
   logic [DW-1:0]   p_sd   [NTHR];
   logic [AW-1:0]   p_aa   [NTHR];
   logic [MW-1:0]   p_am   [NTHR];
   logic [DW-1:0]   p_ad   [NTHR];
   logic [TW-1:0]   gnt_id;
   logic            any_req;

   for (genvar t = 0; t < NTHR; t++) begin : g_part
      sbuf_part #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_part (
         .clk      (clk),
         .rst_n    (rst_n),
         .ins_en   (ins_valid && ins_tid == TW'(t) && !p_full[t]),
         .ins_rmo  (ins_rmo),
         .ins_addr (ins_addr),
         .ins_mask (ins_mask),
         .ins_data (ins_data),
         .full     (p_full[t]),
         .ld_addr  (ld_addr),
         .ld_mask  (ld_mask),
         .ld_hit   (p_hit[t]),
         .ld_conf  (p_conf[t]),
         .ld_data  (p_ldd[t]),
         .snd_req  (p_req[t]),
         .snd_idx  (p_idx[t]),
         .snd_rmo  (p_rmo[t]),
         .snd_addr (p_sa[t]),
         .snd_mask (p_sm[t]),
         .snd_data (p_sd[t]),
         .snd_take (p_gnt[t] && drn_ready),
         .ack_en   (ack_valid && ack_tid == TW'(t)),
         .ack_idx  (ack_idx),
         .ack_addr (p_aa[t]),
         .ack_mask (p_am[t]),
         .ack_data (p_ad[t])
      );
   end

   sbuf_rr_arb #(.N(NTHR)) u_arb (
      .clk    (clk),
      .rst_n  (rst_n),
      .req    (p_req),
      .adv    (drn_ready),
      .gnt    (p_gnt),
      .gnt_id (gnt_id),
      .any    (any_req)
   );

   assign ins_full    = p_full[ins_tid];
   assign ld_hit      = ld_valid && p_hit[ld_tid];
   assign ld_conflict = ld_valid && p_conf[ld_tid];
   assign ld_data     = p_ldd[ld_tid];
   assign drn_valid   = any_req;
   assign drn_tid     = gnt_id;
   assign drn_idx     = p_idx[gnt_id];
   assign drn_rmo     = p_rmo[gnt_id];
   assign drn_addr    = p_sa[gnt_id];
   assign drn_mask    = p_sm[gnt_id];
   assign drn_data    = p_sd[gnt_id];
   assign dc_wr_valid = ack_valid && ack_l1hit;
   assign dc_wr_addr  = p_aa[ack_tid];
   assign dc_wr_mask  = p_am[ack_tid];
   assign dc_wr_data  = p_ad[ack_tid];
endmodule

// File: tb/thrd_store_buffer_bench.sv
`timescale 1ns/1ps
module thrd_store_buffer_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ins_valid = 0, ins_rmo = 0, ld_valid = 0, drn_ready = 0;
   logic        ack_valid = 0, ack_l1hit = 0;
   logic [1:0]  ins_tid = 0, ld_tid = 0, ack_tid = 0;
   logic [2:0]  ack_idx = 0;
   logic [39:0] ins_addr = 0, ld_addr = 0;
   logic [7:0]  ins_mask = 0, ld_mask = 0;
   logic [63:0] ins_data = 0;
   logic        ins_full, ld_hit, ld_conflict, drn_valid, drn_rmo, dc_wr_valid;
   logic [63:0] ld_data, drn_data, dc_wr_data;
   logic [1:0]  drn_tid;
   logic [2:0]  drn_idx;
   logic [39:0] drn_addr, dc_wr_addr;
   logic [7:0]  drn_mask, dc_wr_mask;

   always #2.5 clk = ~clk;

   thrd_store_buffer u_thrd_store_buffer (.*);

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   // Reference model: per thread, a program-order ring indexed by sequence number.
   logic [39:0] m_addr [4][16];
   logic [7:0]  m_mask [4][16];
   logic [63:0] m_data [4][16];
   bit          m_rmo  [4][16];
   bit          m_ack  [4][16];
   int          ins_n [4], head_n [4], snd_n [4];
   bit          tso [4];
   int          rr = 0;
   // Stores sent and not yet acknowledged.
   int          o_tid [64], o_idx [64], o_seq [64];
   int          ocnt = 0;
   int          a_k = 0, a_seq = 0;

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic bit sendable(input int t);
      return snd_n[t] < ins_n[t] && (m_rmo[t][snd_n[t] % 16] || !tso[t]);
   endfunction

   function automatic logic [7:0] pick_mask();
      case ($urandom % 6)
         0: return 8'hFF;
         1: return 8'h0F;
         2: return 8'hF0;
         3: return 8'h03;
         4: return 8'h0C;
         default: return 8'($urandom);
      endcase
   endfunction

   task automatic pick_ack(input int pct);
      if (ocnt > 0 && int'($urandom % 100) < pct) begin
         a_k       = int'($urandom % ocnt);
         ack_valid = 1;
         ack_tid   = 2'(o_tid[a_k]);
         ack_idx   = 3'(o_idx[a_k]);
         a_seq     = o_seq[a_k];
         ack_l1hit = 1'($urandom);
      end else ack_valid = 0;
   endtask

   // One cycle: inputs already driven at the falling edge.
   task automatic tick();
      int g, t, found, s, lt;
      bit efull, acc, fire, blk, ehit, econf;
      logic [2:0] cap_idx;
      string lbl;
      #1;
      t = int'(ins_tid);
      efull = (ins_n[t] - head_n[t]) == 8;
      chk(ins_full == efull, "R2", 64'(ins_full), 64'(efull));
      acc = ins_valid && !efull;
      g = -1; blk = 0;
      for (int k = 0; k < 4; k++) begin
         int u;
         u = (rr + k) % 4;
         if (g < 0 && sendable(u)) g = u;
         if (snd_n[u] < ins_n[u] && !sendable(u)) blk = 1;
      end
      lbl = (g >= 0 && tso[g]) ? "R5" : (blk ? "R4" : "R3");
      chk(drn_valid == (g >= 0), lbl, 64'(drn_valid), 64'(g >= 0));
      if (g >= 0 && drn_valid) begin
         s = snd_n[g] % 16;
         chk(int'(drn_tid) == g, "R10", 64'(drn_tid), 64'(g));
         chk(drn_addr == m_addr[g][s] && drn_mask == m_mask[g][s] && drn_data == m_data[g][s]
             && drn_rmo == m_rmo[g][s], "R3", drn_data, m_data[g][s]);
      end
      fire = g >= 0 && drn_ready;
      cap_idx = drn_idx;
      if (ld_valid) begin
         lt = int'(ld_tid); found = -1;
         for (int q = ins_n[lt] - 1; q >= head_n[lt]; q--)
            if (found < 0 && !m_ack[lt][q % 16] && m_addr[lt][q % 16] == ld_addr
                && (m_mask[lt][q % 16] & ld_mask) != 0) found = q % 16;
         ehit  = found >= 0 && (ld_mask & ~m_mask[lt][found]) == 0;
         econf = found >= 0 && !ehit;
         lbl = ehit ? "R6" : (econf ? "R8" : "R7");
         chk(ld_hit == ehit, lbl, 64'(ld_hit), 64'(ehit));
         chk(ld_conflict == econf, lbl, 64'(ld_conflict), 64'(econf));
         if (ehit && ld_hit) chk(ld_data == m_data[lt][found], "R6", ld_data, m_data[lt][found]);
      end
      chk(dc_wr_valid == (ack_valid && ack_l1hit), "R9", 64'(dc_wr_valid),
          64'(ack_valid && ack_l1hit));
      if (ack_valid && ack_l1hit) begin
         s = a_seq % 16;
         chk(dc_wr_addr == m_addr[ack_tid][s] && dc_wr_mask == m_mask[ack_tid][s]
             && dc_wr_data == m_data[ack_tid][s], "R9", dc_wr_data, m_data[ack_tid][s]);
      end
      @(posedge clk);
      for (int u = 0; u < 4; u++)
         if (head_n[u] < ins_n[u] && m_ack[u][head_n[u] % 16]) head_n[u]++;
      if (acc) begin
         s = ins_n[t] % 16;
         m_addr[t][s] = ins_addr; m_mask[t][s] = ins_mask; m_data[t][s] = ins_data;
         m_rmo[t][s] = ins_rmo; m_ack[t][s] = 0; ins_n[t]++;
      end
      if (ack_valid) begin
         m_ack[ack_tid][a_seq % 16] = 1;
         if (!m_rmo[ack_tid][a_seq % 16]) tso[ack_tid] = 0;
         ocnt--;
         o_tid[a_k] = o_tid[ocnt]; o_idx[a_k] = o_idx[ocnt]; o_seq[a_k] = o_seq[ocnt];
      end
      if (fire) begin
         o_tid[ocnt] = g; o_idx[ocnt] = int'(cap_idx); o_seq[ocnt] = snd_n[g]; ocnt++;
         if (!m_rmo[g][snd_n[g] % 16]) tso[g] = 1;
         snd_n[g]++;
         rr = (g + 1) % 4;
      end
      @(negedge clk);
      ack_valid = 0;
   endtask

   task automatic put(input int t, input bit rmo, input int a, input logic [7:0] m,
                      input logic [63:0] d);
      ins_valid = 1; ins_tid = 2'(t); ins_rmo = rmo; ins_addr = 40'(a);
      ins_mask = m; ins_data = d;
      tick();
      ins_valid = 0;
   endtask

   task automatic look(input int t, input int a, input logic [7:0] m);
      ld_valid = 1; ld_tid = 2'(t); ld_addr = 40'(a); ld_mask = m;
      tick();
      ld_valid = 0;
   endtask

   initial begin
      void'($urandom(32'd20241));
      for (int t = 0; t < 4; t++) begin
         ins_n[t] = 0; head_n[t] = 0; snd_n[t] = 0; tso[t] = 0;
      end
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1;
      #1;
      // R1: empty after reset
      chk(drn_valid == 0, "R1", 64'(drn_valid), 0);
      chk(ins_full == 0, "R1", 64'(ins_full), 0);
      chk(dc_wr_valid == 0, "R1", 64'(dc_wr_valid), 0);
      ld_valid = 1; ld_addr = 0; ld_mask = 8'hFF; #0.5;
      chk(ld_hit == 0 && ld_conflict == 0, "R1", 64'({ld_hit, ld_conflict}), 0);
      ld_valid = 0;
      @(negedge clk);

      // R2: fill thread 0, ninth insert dropped
      drn_ready = 0;
      for (int i = 0; i < 9; i++) put(0, 1, i, 8'hFF, 64'h1000 + 64'(i));
      // R7: other thread sees nothing; R6: owner forwards
      look(1, 3, 8'hFF);
      look(0, 3, 8'h0F);
      // R8: partial coverage, then youngest covering store wins
      put(2, 1, 9, 8'h0F, 64'hAAAA);
      look(2, 9, 8'hFF);
      put(2, 1, 9, 8'hFF, 64'hBBBB);
      look(2, 9, 8'hFF);
      // R10: rotation across threads
      for (int t = 1; t < 4; t++) put(t, 1, 20 + t, 8'hFF, 64'(t));
      drn_ready = 1;
      repeat (14) tick();
      while (ocnt > 0) begin pick_ack(100); tick(); end
      repeat (4) tick();
      // R4: three TSO stores of thread 3 stay serialized
      drn_ready = 0;
      for (int i = 0; i < 3; i++) put(3, 0, 30 + i, 8'hFF, 64'h3000 + 64'(i));
      put(3, 1, 40, 8'hFF, 64'h3333);
      drn_ready = 1;
      repeat (4) tick();
      while (ocnt > 0 || snd_n[3] < ins_n[3]) begin pick_ack(60); tick(); end
      // Random traffic
      for (int c = 0; c < 5000; c++) begin
         ins_valid = 1'(($urandom % 100) < 60);
         ins_tid   = 2'($urandom);
         ins_rmo   = 1'(($urandom % 100) < 55);
         ins_addr  = 40'($urandom % 4);
         ins_mask  = pick_mask();
         ins_data  = {$urandom, $urandom};
         ld_valid  = 1'(($urandom % 100) < 80);
         ld_tid    = 2'($urandom);
         ld_addr   = 40'($urandom % 4);
         ld_mask   = pick_mask();
         drn_ready = 1'(($urandom % 100) < 70);
         pick_ack((c % 400) < 100 ? 5 : 45);
         tick();
      end
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #600000;
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule